// File: doc/BRIEF.md
# Receive FIFO Flow-Control Alert Generator

This block sits beside an Ethernet MAC receive FIFO and raises a flow-control request while the FIFO fills. It keeps two occupancy counts: the bytes held in the FIFO and the complete frames held in it. It updates both counts from per-cycle strobes. A byte write or read strobe moves the byte count. A frame-complete or frame-drained pulse moves the frame count.

Software supplies a frame threshold code, a byte threshold code and the FIFO size code. The alert is raised when either the frame count or the byte count reaches its threshold. It is released only when neither count is at or above its threshold. The alert comes from a register, so the MAC sees a clean level that changes one cycle after the count that crossed a threshold.

All pins are plain control and status signals with no handshake. Each strobe counts once for every cycle it is high. The suggested reset values for the registers that feed the threshold codes are 0x17 for the frame code (24 frames) and all ones for the byte code. Those registers are outside this block.

Top module: `rxfc_alert`

## Requirements
- R1: A synchronous reset clears the byte count, the frame count and the alert, and the alert reads 0 in the cycle after reset.
- R2: A cycle with `byte_wr` high adds one to the byte count and a cycle with `byte_rd` high removes one. When both are high in the same cycle, the count stays unchanged. The count does not rise above the FIFO size and does not fall below zero.
- R3: A cycle with `frm_done` high adds one to the frame count and a cycle with `frm_drain` high removes one. When both are high in the same cycle, the count stays unchanged. The count saturates at 31 and at zero.
- R4: The frame condition holds when the frame count is at least `frm_thr`+1. For example, code 0 means 1 frame and code 23 means 24 frames.
- R5: The FIFO size in bytes is (`depth_code`+1)×256. When `byte_thr` is below `depth_code`, the byte condition holds when the byte count is at least (`byte_thr`+1)×256.
- R6: When `byte_thr` equals `depth_code`, the byte condition holds when the byte count is at least the FIFO size minus 64.
- R7: A `byte_thr` above `depth_code` acts as if it equals `depth_code`, so the R6 rule applies.
- R8: `alert` goes high one cycle after the counts first satisfy the frame condition or the byte condition, whichever comes first.
- R9: `alert` goes low one cycle after the counts satisfy neither condition, and stays high while either condition still holds.
- R10: A `depth_code` above the parameter `MAX_SIZE_CODE` acts as `MAX_SIZE_CODE`, both for the FIFO size and for the threshold rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_wr | input | 1 | One byte written into the receive FIFO this cycle |
| byte_rd | input | 1 | One byte read out of the receive FIFO this cycle |
| frm_done | input | 1 | One complete frame has finished storing this cycle |
| frm_drain | input | 1 | One stored frame has been fully removed this cycle |
| frm_thr | input | FRM_CODE_W (5) | Frame threshold code N. The alert needs N+1 stored frames |
| byte_thr | input | SIZE_CODE_W (8) | Byte threshold code, in units of 256 bytes |
| depth_code | input | SIZE_CODE_W (8) | FIFO size code. The size is (code+1)×256 bytes |
| alert | output | 1 | Registered flow-control request to the MAC |

## Verification
Assertions run on every cycle and check how the counters step. They check the increment, that a simultaneous strobe pair leaves a count unchanged, and that a count holds at its ceiling. They also check that a met frame or byte condition is followed by a high alert, and that the alert falls only after the frame count has dropped back to or below its code. The exact threshold values depend on the codes: the N+1 frame rule, the (code+1)×256 byte steps, the minus-64 substitution, the clamping of oversized codes, and how the two conditions combine on release. The bench's sweeps show these. They fill and drain the counters under every code combination of a small configuration and compare the alert with the value computed for each cycle.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  // Number of bytes in one step of a size or threshold code.
  localparam int unsigned BYTES_PER_CODE = 256;
  // Number of bytes removed from the size when the threshold equals the size.
  localparam int unsigned FULL_MARGIN    = 64;

  // Counter width that can hold the largest FIFO size.
  function automatic int unsigned byte_cnt_width(input int unsigned max_code);
    return $clog2((max_code + 1) * BYTES_PER_CODE + 1);
  endfunction
endpackage

// File: rtl/rxfc_occ_counter.sv
module rxfc_occ_counter #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  input  logic [W-1:0] max_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (cnt < max_val) cnt <= cnt + W'(1);
        2'b01:   if (cnt != '0)     cnt <= cnt - W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt < max_val) |=> cnt == $past(cnt) + W'(1)); // R2
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - W'(1)); // R3
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(cnt)); // R2
  AST_CEIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt == max_val) |=> $stable(cnt)); // R3
endmodule

// File: rtl/rxfc_byte_limit.sv
module rxfc_byte_limit
  import rxfc_pkg::*;
#(
  parameter int unsigned CODE_W        = 8,
  parameter int unsigned MAX_SIZE_CODE = 7,
  parameter int unsigned CNT_W         = byte_cnt_width(MAX_SIZE_CODE)
) (
  input  logic [CODE_W-1:0] thr_code,
  input  logic [CODE_W-1:0] depth_code,
  output logic [CNT_W-1:0]  fifo_size,
  output logic [CNT_W-1:0]  limit
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_SIZE_CODE);
  localparam int unsigned       SHIFT    = $clog2(BYTES_PER_CODE);

  logic [CODE_W-1:0] depth_eff;
  logic [CODE_W-1:0] thr_eff;

  always_comb begin
    depth_eff = (depth_code > MAX_CODE) ? MAX_CODE : depth_code;
    thr_eff   = (thr_code > depth_eff) ? depth_eff : thr_code;
    fifo_size = (CNT_W'(depth_eff) + CNT_W'(1)) << SHIFT;
    if (thr_eff == depth_eff) begin
      limit = fifo_size - CNT_W'(FULL_MARGIN);
    end else begin
      limit = (CNT_W'(thr_eff) + CNT_W'(1)) << SHIFT;
    end
  end
endmodule

// File: rtl/rxfc_alert.sv
module rxfc_alert
  import rxfc_pkg::*;
#(
  parameter int unsigned SIZE_CODE_W   = 8,
  parameter int unsigned FRM_CODE_W    = 5,
  parameter int unsigned MAX_SIZE_CODE = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   byte_wr,
  input  logic                   byte_rd,
  input  logic                   frm_done,
  input  logic                   frm_drain,
  input  logic [FRM_CODE_W-1:0]  frm_thr,
  input  logic [SIZE_CODE_W-1:0] byte_thr,
  input  logic [SIZE_CODE_W-1:0] depth_code,
  output logic                   alert
);
  localparam int unsigned BCNT_W = byte_cnt_width(MAX_SIZE_CODE);

  logic [BCNT_W-1:0]     byte_cnt;
  logic [BCNT_W-1:0]     fifo_size;
  logic [BCNT_W-1:0]     byte_limit;
  logic [FRM_CODE_W-1:0] frm_cnt;
  logic                  frm_hit;
  logic                  byte_hit;

  rxfc_byte_limit #(
    .CODE_W       (SIZE_CODE_W),
    .MAX_SIZE_CODE(MAX_SIZE_CODE),
    .CNT_W        (BCNT_W)
  ) u_limit (
    .thr_code  (byte_thr),
    .depth_code(depth_code),
    .fifo_size (fifo_size),
    .limit     (byte_limit)
  );

  rxfc_occ_counter #(.W(BCNT_W)) u_bytes (
    .clk    (clk),
    .rst    (rst),
    .inc    (byte_wr),
    .dec    (byte_rd),
    .max_val(fifo_size),
    .cnt    (byte_cnt)
  );

  rxfc_occ_counter #(.W(FRM_CODE_W)) u_frames (
    .clk    (clk),
    .rst    (rst),
    .inc    (frm_done),
    .dec    (frm_drain),
    .max_val({FRM_CODE_W{1'b1}}),
    .cnt    (frm_cnt)
  );

  assign frm_hit  = (frm_cnt > frm_thr);
  assign byte_hit = (byte_cnt >= byte_limit);

  always_ff @(posedge clk) begin
    if (rst) alert <= 1'b0;
    else     alert <= frm_hit | byte_hit;
  end

  AST_FRAME_RAISE: assert property (@(posedge clk) disable iff (rst)
    (frm_cnt > frm_thr) |=> alert); // R8
  AST_BYTE_RAISE: assert property (@(posedge clk) disable iff (rst)
    (byte_cnt >= byte_limit) |=> alert); // R8
  AST_RELEASE_FRAMES: assert property (@(posedge clk) disable iff (rst)
    $fell(alert) |-> ($past(frm_cnt) <= $past(frm_thr))); // R9
  AST_BYTE_CEIL: assert property (@(posedge clk) disable iff (rst)
    (byte_cnt == fifo_size && byte_wr && !byte_rd) |=> (byte_cnt == $past(byte_cnt))); // R2
endmodule

// File: tb/rxfc_alert_tb_top.sv
`timescale 1ns/1ps
module rxfc_alert_tb_top;
  localparam int MAXC = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_wr = 0, byte_rd = 0, frm_done = 0, frm_drain = 0;
  logic [4:0] frm_thr = 5'h17;
  logic [7:0] byte_thr = 8'hff;
  logic [7:0] depth_code = 8'd0;
  logic       alert;

  int n_run = 0;
  int n_fail = 0;
  int mb = 0;
  int mf = 0;
  bit exp_alert = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  rxfc_alert #(.SIZE_CODE_W(8), .FRM_CODE_W(5), .MAX_SIZE_CODE(MAXC)) dut_i (
    .clk(clk), .rst(rst), .byte_wr(byte_wr), .byte_rd(byte_rd),
    .frm_done(frm_done), .frm_drain(frm_drain), .frm_thr(frm_thr),
    .byte_thr(byte_thr), .depth_code(depth_code), .alert(alert)
  );

  function automatic int size_of();
    int d = (depth_code > MAXC) ? MAXC : int'(depth_code);
    return (d + 1) * 256;
  endfunction

  function automatic int limit_of();
    int d = (depth_code > MAXC) ? MAXC : int'(depth_code);
    int t = (byte_thr > d) ? d : int'(byte_thr);
    return (t == d) ? (d + 1) * 256 - 64 : (t + 1) * 256;
  endfunction

  function automatic bit cond_of(input int b, input int f);
    return (f >= int'(frm_thr) + 1) || (b >= limit_of());
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: alert=%0b expected=%0b (bytes=%0d frames=%0d)", tag, act, exp, mb, mf);
    end
  endtask

  task automatic step(input bit w, input bit r, input bit fc, input bit fd, input string tag);
    @(negedge clk);
    check(alert, exp_alert, tag);
    exp_alert = cond_of(mb, mf);
    byte_wr = w; byte_rd = r; frm_done = fc; frm_drain = fd;
    if (w && !r && mb < size_of()) mb++;
    if (r && !w && mb > 0) mb--;
    if (fc && !fd && mf < 31) mf++;
    if (fd && !fc && mf > 0) mf--;
  endtask

  task automatic do_reset(input int d, input int bt, input int ft);
    @(negedge clk);
    rst = 1; byte_wr = 0; byte_rd = 0; frm_done = 0; frm_drain = 0;
    depth_code = 8'(d); byte_thr = 8'(bt); frm_thr = 5'(ft);
    @(negedge clk);
    @(negedge clk);
    check(alert, 1'b0, "R1");
    rst = 0; mb = 0; mf = 0; exp_alert = 0;
  endtask

  function automatic string byte_tag(input int d, input int t);
    if (d > MAXC) return "R10";
    if (t > d) return "R7";
    if (t == d) return "R6";
    return "R5";
  endfunction

  initial begin
    // Byte threshold sweep: fill past the size (R2 ceiling), hold with paired strobes, drain (R9).
    for (int d = 0; d <= MAXC + 1; d++) begin
      for (int t = 0; t <= MAXC + 1; t++) begin
        do_reset(d, t, 31);
        for (int i = 0; i < size_of() + 3; i++) step(1, 0, 0, 0, byte_tag(d, t));
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R2");
        for (int i = 0; i < size_of() + 3; i++) step(0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, "R9");
      end
    end
    // Frame threshold sweep: count up past saturation, pair pulses, drain.
    for (int n = 0; n < 32; n++) begin
      do_reset(1, 1, n);
      for (int i = 0; i < 33; i++) step(0, 0, 1, 0, "R4");
      for (int i = 0; i < 2; i++) step(0, 0, 1, 1, "R3");
      for (int i = 0; i < 33; i++) step(0, 0, 0, 1, "R9");
      step(0, 0, 0, 0, "R9");
    end
    // Both conditions together: alert holds until the second one clears.
    do_reset(1, 0, 1);
    for (int i = 0; i < 256; i++) step(1, 0, 0, 0, "R8");
    for (int i = 0; i < 2; i++) step(0, 0, 1, 0, "R8");
    for (int i = 0; i < 256; i++) step(0, 1, 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, "R9");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected<=150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule